// File: doc/BRIEF.md
# Serial Switch Control Register with Cascade Output

This block holds the on/off state of a bank of switch channels and is programmed over a three-wire serial link. The link has an active-low frame signal, a serial clock and a data line. All three arrive asynchronously and are resampled by the block's own system clock.

While the frame signal is low, each falling serial-clock edge shifts one data bit into an internal shift register, most significant bit first. When the frame signal returns high, the whole shift register is copied to the switch outputs in one step. Between frames the switch outputs never move.

The bit leaving the top of the shift register is presented on a serial output. It is updated at the start of a frame and on each rising serial-clock edge inside a frame. During a write, it therefore streams out the word of the previous write. Several units can share the clock and frame lines, with each unit's serial output feeding the next unit's data input. One long frame then loads the whole cascade. The serial output is given as a data bit together with a pull-low enable, as for a line that is only ever pulled low. An asynchronous active-low reset clears all state.

Top module: `swreg_chain`

## Requirements
- R1: While reset is low, and after it is released, every switch output is 0 (open), the shift register is zero, the serial data bit is 0 and the pull-low enable is 1.
- R2: A frame carries bits sent most significant first. After the frame ends, switch output i equals the i-th bit of the word (bit 7 was sent first), and 1 means closed.
- R3: A data bit is captured only on a falling serial-clock edge seen while the frame signal is low.
- R4: Serial-clock and data activity while the frame signal is high changes neither the switch outputs nor the shift register. The next frame still streams out the unchanged previous word.
- R5: Switch outputs stay constant throughout a frame and change only in response to the frame signal rising.
- R6: A frame with more than 8 falling clock edges applies the last 8 bits received.
- R7: A frame with fewer than k<8 falling edges applies the old contents shifted up by k, with the k new bits at the bottom.
- R8: The serial output equals the shift register's top bit. It is loaded at frame start and after each rising clock edge in the frame, so a second unit fed from it ends a 16-bit frame holding the first 8 bits sent.
- R9: The pull-low enable is always the inverse of the serial data bit.
- R10: Reset asserted in the middle of a frame immediately clears the switch outputs and the serial output bit.
- R11: A falling serial-clock edge detected in the same system cycle as the frame's end is not shifted in. The word latched is the contents before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to resample the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock, idle high |
| frame_n | input | 1 | Active-low frame signal |
| ser_din | input | 1 | Serial data input |
| sw_on | output | NCH | Switch control, 1 = closed |
| dout_bit | output | 1 | Cascade serial output bit |
| dout_pull_en | output | 1 | Pull-low enable for the serial output line |

## Verification
The two functions that can coincide are the capture of a bit on a falling serial-clock edge and the latch of the word when the frame ends. The bench provokes this by changing the serial clock and the frame signal in the same time step, so both pass through identical synchronizers and are detected in the same system cycle. It judges the result by expecting the latched switch word, and the cascaded unit's word, to equal the model's contents without that final bit. It then confirms that the following frame streams out that same word.

// File: rtl/swreg_chain.sv
module swreg_chain #(
  parameter int NCH         = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ser_clk,
  input  logic           frame_n,
  input  logic           ser_din,
  output logic [NCH-1:0] sw_on,
  output logic           dout_bit,
  output logic           dout_pull_en
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] clk_sy, frm_sy, din_sy;
  logic                   clk_d, frm_d;
  logic [NCH-1:0]         sreg;
  logic                   dout_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sy <= '1;
      frm_sy <= '1;
      din_sy <= '0;
      clk_d  <= 1'b1;
      frm_d  <= 1'b1;
    end else begin
      clk_sy <= {clk_sy[SYNC_STAGES-2:0], ser_clk};
      frm_sy <= {frm_sy[SYNC_STAGES-2:0], frame_n};
      din_sy <= {din_sy[SYNC_STAGES-2:0], ser_din};
      clk_d  <= clk_sy[TOP];
      frm_d  <= frm_sy[TOP];
    end
  end

  wire din_s       = din_sy[TOP];
  wire frame_on    = ~frm_sy[TOP];
  wire sclk_fall   = clk_d & ~clk_sy[TOP];
  wire sclk_rise   = ~clk_d & clk_sy[TOP];
  wire frame_start = frm_d & ~frm_sy[TOP];
  wire frame_end   = ~frm_d & frm_sy[TOP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg   <= '0;
      sw_on  <= '0;
      dout_q <= 1'b0;
    end else begin
      if (sclk_fall && frame_on)
        sreg <= {sreg[NCH-2:0], din_s};
      if (frame_end)
        sw_on <= sreg;
      if (frame_start || (sclk_rise && frame_on))
        dout_q <= sreg[NCH-1];
    end
  end

  assign dout_bit     = dout_q;
  assign dout_pull_en = ~dout_q;
endmodule

// File: rtl/swreg_chain_chk.sv
module swreg_chain_chk #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sclk_fall,
  input logic           sclk_rise,
  input logic           frame_on,
  input logic           frame_start,
  input logic           frame_end,
  input logic           din_s,
  input logic [NCH-1:0] sreg,
  input logic [NCH-1:0] sw_on,
  input logic           dout_bit
);
  always @(posedge clk) begin
    if (!rst_n)
      assert_reset_clear_R1: assert (sw_on == '0 && sreg == '0 && dout_bit == 1'b0);
  end

  assert_latch_copy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> sw_on == $past(sreg));

  assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_fall && frame_on) |=> sreg[0] == $past(din_s));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_on |=> $stable(sreg));

  assert_switch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sw_on) |-> $past(frame_end));

  assert_dout_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout_bit) |-> $past(frame_start || (sclk_rise && frame_on)));
endmodule

bind swreg_chain swreg_chain_chk #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sclk_fall  (sclk_fall),
  .sclk_rise  (sclk_rise),
  .frame_on   (frame_on),
  .frame_start(frame_start),
  .frame_end  (frame_end),
  .din_s      (din_s),
  .sreg       (sreg),
  .sw_on      (sw_on),
  .dout_bit   (dout_bit)
);

// File: tb/swreg_chain_bench.sv
module swreg_chain_bench;
  localparam int PH = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b1;
  logic frame_n = 1'b1;
  logic ser_din = 1'b0;
  logic [7:0] sw1, sw2;
  logic d1, p1, d2, p2;

  logic [7:0] m1 = '0, m2 = '0, l1 = '0, l2 = '0;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  swreg_chain u_swreg_chain (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .frame_n(frame_n), .ser_din(ser_din),
    .sw_on(sw1), .dout_bit(d1), .dout_pull_en(p1));

  swreg_chain u_swreg_chain_b (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .frame_n(frame_n), .ser_din(d1),
    .sw_on(sw2), .dout_bit(d2), .dout_pull_en(p2));

  function automatic logic [7:0] shift_in(input logic [7:0] m, input logic b);
    return {m[6:0], b};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_dout(input string req);
    chk(req, {7'd0, d1}, {7'd0, m1[7]});
    chk(req, {7'd0, d2}, {7'd0, m2[7]});
    chk("R9", {7'd0, p1}, {7'd0, ~m1[7]});
  endtask

  task automatic begin_frame();
    frame_n = 1'b0;
    wait_clks(PH);
    check_dout("R8");
  endtask

  task automatic send_bit(input logic b);
    logic b2;
    ser_din = b;
    wait_clks(PH);
    ser_clk = 1'b0;
    b2 = m1[7];
    m1 = shift_in(m1, b);
    m2 = shift_in(m2, b2);
    wait_clks(PH);
    ser_clk = 1'b1;
    wait_clks(PH);
    check_dout("R8");
    chk("R5", sw1, l1);
  endtask

  task automatic end_frame(input string req);
    frame_n = 1'b1;
    wait_clks(PH);
    l1 = m1;
    l2 = m2;
    chk(req, sw1, l1);
    chk(req, sw2, l2);
  endtask

  task automatic send_word(input logic [31:0] w, input int n, input string req);
    begin_frame();
    for (int i = n - 1; i >= 0; i--) send_bit(w[i]);
    end_frame(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired (all requirements) actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd17));
    wait_clks(3);
    chk("R1", sw1, 8'h00);
    chk("R1", {6'd0, d1, p1}, 8'h01);
    rst_n = 1'b1;
    wait_clks(PH);
    chk("R1", sw1, 8'h00);

    send_word(32'hA5, 8, "R2");
    chk("R2", sw1, 8'hA5);

    // R4: activity with frame high
    for (int i = 0; i < 5; i++) begin
      ser_din = i[0];
      wait_clks(PH);
      ser_clk = 1'b0;
      wait_clks(PH);
      ser_clk = 1'b1;
      wait_clks(PH);
      chk("R4", sw1, 8'hA5);
    end
    send_word(32'h3C, 8, "R4");
    chk("R3", sw1, 8'h3C);
    chk("R8", sw2, 8'hA5);

    send_word(32'hFFF_0F1, 12, "R6");
    chk("R6", sw1, 8'hF1);

    send_word(32'h5, 3, "R7");
    chk("R7", sw1, 8'h8D);

    send_word(32'h12C3, 16, "R8");
    chk("R8", sw1, 8'hC3);
    chk("R8", sw2, 8'h12);

    // R11: final falling edge coincides with frame end
    begin_frame();
    send_bit(1'b1);
    send_bit(1'b0);
    ser_din = 1'b1;
    wait_clks(PH);
    ser_clk = 1'b0;
    frame_n = 1'b1;
    wait_clks(PH);
    l1 = m1;
    l2 = m2;
    chk("R11", sw1, l1);
    chk("R11", sw2, l2);
    ser_clk = 1'b1;
    wait_clks(PH);
    begin_frame();
    end_frame("R11");

    // R10: reset in the middle of a frame
    begin_frame();
    send_bit(1'b1);
    send_bit(1'b1);
    rst_n = 1'b0;
    wait_clks(2);
    chk("R10", sw1, 8'h00);
    chk("R10", {6'd0, d1, p1}, 8'h01);
    frame_n = 1'b1;
    wait_clks(2);
    rst_n = 1'b1;
    m1 = '0; m2 = '0; l1 = '0; l2 = '0;
    wait_clks(PH);
    chk("R10", sw2, 8'h00);
    send_word(32'h00, 8, "R1");

    for (int f = 0; f < 30; f++) begin
      int n;
      logic [31:0] w;
      n = 1 + int'($urandom_range(19));
      w = $urandom;
      send_word(w, n, (n > 8) ? "R6" : (n < 8) ? "R7" : "R2");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule